// File: doc/BRIEF.md
# Calibrated Multi-Channel ADC Sequencer

This block runs a group of up to eight converter channels that all start and finish on one shared clock. It steps through four fixed phases: ground reference, signal, supply reference, signal. During each phase it sums eight raw results per channel. Afterwards it copies those sums into one of three level banks (ground, supply, signal) and clears the sums. A downstream scaler later turns the three banks into calibrated readings. This block holds the raw sums only. The converter and the arithmetic are outside it.

The enabled channels form a window. Software gives the lowest channel number and the channel count minus one. The window stops at the highest channel and does not wrap. A conversion event is the done strobe of the window's lowest channel. The block answers each event with an acknowledge pulse to every channel in the window. Three FSM states sort the events of a phase. `ST_ACCUM` covers events one to eight and adds the results. `ST_MOVE` covers event nine and copies the sums to a bank. `ST_CLEAR` covers event ten, zeroes the sums and advances the phase. The transitions are ACCUM to MOVE on the eighth event, MOVE to CLEAR on the next event, and CLEAR to ACCUM on the event after that. On the eighth event the block also switches the channel mode to the one the next phase needs. During the accumulating events, a one-cycle strobe with an index tells the scaler which channel slot to compute.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are as follows until the first event: mode is ground-reference (code 1), phase is 0, no acknowledge, no calculation strobe, all three banks read 0.
- R2: An event occurs only when `conv_done` of channel `cfg_base` is high at a clock edge while `conv_ack` is low. The block then drives `conv_ack` high for exactly one cycle on the window's channels. A done strobe on any other channel, or a done that is still high during the acknowledge cycle, is ignored.
- R3: The window is the channels c with cfg_base <= c <= cfg_base+cfg_last, clipped at channel NCH-1. Channels outside the window are never acknowledged and their bank entries stay 0.
- R4: Each of the first eight events of a phase adds every window channel's 10-bit result from `conv_data[c*10 +: 10]` to that channel's sum.
- R5: On the eighth event of phase p, `chan_mode` changes to the mode of phase p+1 mod 4. The codes are: normal 0, ground-reference 1, supply-reference 2. The phase modes are 1, 0, 2, 0 for phases 0 to 3.
- R6: On the ninth event the sums are copied to a bank. Phase 0 writes the ground bank, phase 2 writes the supply bank, and phases 1 and 3 write the signal bank. Results arriving on the ninth and tenth events are discarded.
- R7: On the tenth event all sums are cleared and the phase advances by one, modulo 4.
- R8: After each of the first eight events of a phase, `calc_stb` is high for one cycle and `calc_idx` gives the event number 0 to 7.
- R9: A sum of eight full-scale results (8184) fits in the 13-bit level outputs without wrapping.
- R10: `phase` follows 0, 1, 2, 3, 0 and changes only on the tenth event of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 3 | Lowest channel of the window; its done strobe defines events |
| cfg_last | input | 3 | Channel count minus one |
| conv_done | input | 8 | Per-channel conversion-done strobe |
| conv_data | input | 80 | Per-channel 10-bit raw result, channel c at bits c*10 +: 10 |
| conv_ack | output | 8 | Per-channel acknowledge pulse |
| chan_mode | output | 2 | Channel mode code for the converters |
| phase | output | 2 | Current phase 0 to 3 |
| calc_stb | output | 1 | One-cycle strobe after each accumulating event |
| calc_idx | output | 3 | Event number within the phase, valid with calc_stb |
| rd_ch | input | 3 | Channel selected on the bank read ports |
| gnd_level | output | 13 | Ground bank entry of channel rd_ch |
| sup_level | output | 13 | Supply bank entry of channel rd_ch |
| sig_level | output | 13 | Signal bank entry of channel rd_ch |

## Verification
Full-scale results on every channel test that sums of 8184 neither wrap nor spill into other entries. Random data tells apart channels that were added from ones that were skipped. A per-channel ramp shows whether results land in their own channel's entries and whether the ninth and tenth results are left out. The window is tried full-width, at the top end, clipped at the last channel and as a single channel, which separates correct masking from off-by-one edges. Some runs also hold done through the acknowledge cycle or pulse done on a channel that is not the base, to show that neither case counts as an event.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int unsigned SUMS = 8;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_MOVE  = 2'd1,
        ST_CLEAR = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_GND    = 2'd1,
        MODE_SUP    = 2'd2
    } chan_mode_t;

    typedef enum logic [1:0] {
        BANK_GND = 2'd0,
        BANK_SUP = 2'd1,
        BANK_SIG = 2'd2
    } bank_sel_t;

    function automatic chan_mode_t phase_mode(input logic [1:0] ph);
        chan_mode_t m;
        unique case (ph)
            2'd0:    m = MODE_GND;
            2'd2:    m = MODE_SUP;
            default: m = MODE_NORMAL;
        endcase
        return m;
    endfunction

    function automatic bank_sel_t phase_bank(input logic [1:0] ph);
        bank_sel_t b;
        unique case (ph)
            2'd0:    b = BANK_GND;
            2'd2:    b = BANK_SUP;
            default: b = BANK_SIG;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CH_W = $clog2(NCH),
    localparam int CNT_W = $clog2(SUMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  cfg_base,
    input  logic [CH_W-1:0]  cfg_last,
    input  logic [NCH-1:0]   conv_done,
    output logic [NCH-1:0]   conv_ack,
    output logic [NCH-1:0]   act_mask,
    output logic             acc_en,
    output logic             move_en,
    output logic             clear_en,
    output bank_sel_t        bank_sel,
    output logic [1:0]       chan_mode,
    output logic [1:0]       phase,
    output logic             calc_stb,
    output logic [CNT_W-1:0] calc_idx
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SUMS - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       phase_q, phase_d;
    logic [NCH-1:0]   ack_q;
    chan_mode_t       mode_q;
    logic             stb_q;
    logic [CNT_W-1:0] idx_q;
    logic [CH_W:0]    win_lo, win_hi;
    logic             evt;
    logic             last_acc;

    // channel window, clipped at the top channel
    assign win_lo = {1'b0, cfg_base};
    assign win_hi = {1'b0, cfg_base} + {1'b0, cfg_last};

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_win
            localparam logic [CH_W:0] CH_IDX = (CH_W+1)'(gi);
            assign act_mask[gi] = (CH_IDX >= win_lo) && (CH_IDX <= win_hi);
        end
    endgenerate

    // an event needs the base done strobe and no acknowledge in flight
    assign evt      = conv_done[cfg_base] & ~(|ack_q);
    assign last_acc = (state_q == ST_ACCUM) && (cnt_q == LAST_CNT);

    assign acc_en   = evt && (state_q == ST_ACCUM);
    assign move_en  = evt && (state_q == ST_MOVE);
    assign clear_en = evt && (state_q == ST_CLEAR);
    assign bank_sel = phase_bank(phase_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        phase_d = phase_q;
        if (evt) begin
            unique case (state_q)
                ST_ACCUM: begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_CNT) begin
                        state_d = ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    state_d = ST_CLEAR;
                end
                ST_CLEAR: begin
                    state_d = ST_ACCUM;
                    phase_d = phase_q + 2'd1;
                end
                default: begin
                    state_d = ST_ACCUM;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACCUM;
            cnt_q   <= '0;
            phase_q <= 2'd0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= '0;
            mode_q <= MODE_GND;
            stb_q  <= 1'b0;
            idx_q  <= '0;
        end else begin
            ack_q <= evt ? act_mask : '0;
            stb_q <= acc_en;
            if (acc_en) begin
                idx_q <= cnt_q;
            end
            if (evt && last_acc) begin
                mode_q <= phase_mode(phase_q + 2'd1);
            end
        end
    end

    assign conv_ack  = ack_q;
    assign chan_mode = mode_q;
    assign phase     = phase_q;
    assign calc_stb  = stb_q;
    assign calc_idx  = idx_q;

endmodule

// File: rtl/adcseq_accum.sv
module adcseq_accum #(
    parameter int NCH    = 8,
    parameter int DATA_W = 10,
    parameter int ACC_W  = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_en,
    input  logic                  clear_en,
    input  logic [NCH-1:0]        act_mask,
    input  logic [NCH*DATA_W-1:0] conv_data,
    output logic [NCH*ACC_W-1:0]  acc_flat
);

    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_ch
            logic [ACC_W-1:0] sum_q;
            always_ff @(posedge clk) begin
                if (!rst_n || clear_en) begin
                    sum_q <= '0;
                end else if (acc_en && act_mask[gc]) begin
                    sum_q <= sum_q + ACC_W'(conv_data[gc*DATA_W +: DATA_W]);
                end
            end
            assign acc_flat[gc*ACC_W +: ACC_W] = sum_q;
        end
    endgenerate

endmodule

// File: rtl/adcseq_banks.sv
module adcseq_banks
    import adcseq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int ACC_W = 13,
    localparam int CH_W = $clog2(NCH),
    localparam int NBANK = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   move_en,
    input  bank_sel_t              bank_sel,
    input  logic [NCH*ACC_W-1:0]   acc_flat,
    input  logic [CH_W-1:0]        rd_ch,
    output logic [NBANK*ACC_W-1:0] rd_flat
);

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank
            logic [NCH*ACC_W-1:0] lvl_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= '0;
                end else if (move_en && (int'(bank_sel) == gb)) begin
                    lvl_q <= acc_flat;
                end
            end
            assign rd_flat[gb*ACC_W +: ACC_W] = lvl_q[int'(rd_ch)*ACC_W +: ACC_W];
        end
    endgenerate

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adcseq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 10,
    localparam int CH_W  = $clog2(NCH),
    localparam int CNT_W = $clog2(SUMS),
    localparam int ACC_W = DATA_W + $clog2(SUMS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH_W-1:0]       cfg_base,
    input  logic [CH_W-1:0]       cfg_last,
    input  logic [NCH-1:0]        conv_done,
    input  logic [NCH*DATA_W-1:0] conv_data,
    output logic [NCH-1:0]        conv_ack,
    output logic [1:0]            chan_mode,
    output logic [1:0]            phase,
    output logic                  calc_stb,
    output logic [CNT_W-1:0]      calc_idx,
    input  logic [CH_W-1:0]       rd_ch,
    output logic [ACC_W-1:0]      gnd_level,
    output logic [ACC_W-1:0]      sup_level,
    output logic [ACC_W-1:0]      sig_level
);

    logic [NCH-1:0]       act_mask;
    logic                 acc_en, move_en, clear_en;
    bank_sel_t            bank_sel;
    logic [NCH*ACC_W-1:0] acc_flat;
    logic [3*ACC_W-1:0]   rd_flat;

    adcseq_ctrl #(.NCH(NCH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_base  (cfg_base),
        .cfg_last  (cfg_last),
        .conv_done (conv_done),
        .conv_ack  (conv_ack),
        .act_mask  (act_mask),
        .acc_en    (acc_en),
        .move_en   (move_en),
        .clear_en  (clear_en),
        .bank_sel  (bank_sel),
        .chan_mode (chan_mode),
        .phase     (phase),
        .calc_stb  (calc_stb),
        .calc_idx  (calc_idx)
    );

    adcseq_accum #(.NCH(NCH), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .clear_en  (clear_en),
        .act_mask  (act_mask),
        .conv_data (conv_data),
        .acc_flat  (acc_flat)
    );

    adcseq_banks #(.NCH(NCH), .ACC_W(ACC_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .move_en  (move_en),
        .bank_sel (bank_sel),
        .acc_flat (acc_flat),
        .rd_ch    (rd_ch),
        .rd_flat  (rd_flat)
    );

    assign gnd_level = rd_flat[int'(BANK_GND)*ACC_W +: ACC_W];
    assign sup_level = rd_flat[int'(BANK_SUP)*ACC_W +: ACC_W];
    assign sig_level = rd_flat[int'(BANK_SIG)*ACC_W +: ACC_W];

endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk
    import adcseq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 10,
    localparam int CH_W  = $clog2(NCH),
    localparam int ACC_W = DATA_W + $clog2(SUMS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CH_W-1:0]  cfg_base,
    input logic [CH_W-1:0]  cfg_last,
    input logic [NCH-1:0]   conv_done,
    input logic [NCH-1:0]   conv_ack,
    input logic [1:0]       chan_mode,
    input logic [1:0]       phase,
    input logic             calc_stb,
    input logic [ACC_W-1:0] gnd_level,
    input logic [ACC_W-1:0] sup_level,
    input logic [ACC_W-1:0] sig_level
);

    localparam int MAX_SUM = int'(SUMS) * ((1 << DATA_W) - 1);

    logic [NCH-1:0] win;
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            win[c] = (c >= int'(cfg_base)) && (c <= int'(cfg_base) + int'(cfg_last));
        end
    end

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|conv_ack) |=> (conv_ack == '0));

    assert_ack_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|conv_ack) |-> $past(conv_done[cfg_base]));

    assert_ack_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_ack & ~win) == '0);

    assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_mode != 2'd3);

    assert_mode_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_mode) |-> (|conv_ack));

    assert_phase_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> ((phase == $past(phase) + 2'd1) && (|conv_ack)));

    assert_stb_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        calc_stb |-> (|conv_ack));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gnd_level) <= MAX_SUM) && (int'(sup_level) <= MAX_SUM)
        && (int'(sig_level) <= MAX_SUM));

endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_base  (cfg_base),
    .cfg_last  (cfg_last),
    .conv_done (conv_done),
    .conv_ack  (conv_ack),
    .chan_mode (chan_mode),
    .phase     (phase),
    .calc_stb  (calc_stb),
    .gnd_level (gnd_level),
    .sup_level (sup_level),
    .sig_level (sig_level)
);

// File: tb/adc_cal_sequencer_tb.sv
module adc_cal_sequencer_tb;

    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int AW  = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      cfg_base = '0;
    logic [2:0]      cfg_last = '0;
    logic [NCH-1:0]  conv_done = '0;
    logic [NCH*DW-1:0] conv_data = '0;
    logic [NCH-1:0]  conv_ack;
    logic [1:0]      chan_mode;
    logic [1:0]      phase;
    logic            calc_stb;
    logic [2:0]      calc_idx;
    logic [2:0]      rd_ch = '0;
    logic [AW-1:0]   gnd_level, sup_level, sig_level;

    always #5 clk = ~clk;

    adc_cal_sequencer #(.NCH(NCH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_last(cfg_last),
        .conv_done(conv_done), .conv_data(conv_data), .conv_ack(conv_ack),
        .chan_mode(chan_mode), .phase(phase), .calc_stb(calc_stb),
        .calc_idx(calc_idx), .rd_ch(rd_ch), .gnd_level(gnd_level),
        .sup_level(sup_level), .sig_level(sig_level)
    );

    int checks = 0;
    int errors = 0;
    int steps  = 0;
    bit done_flag = 0;

    // behavioural reference
    int m_acc[NCH];
    int m_gnd[NCH];
    int m_sup[NCH];
    int m_sig[NCH];
    int m_ph, m_cnt, m_mode, m_ack, m_stb, m_idx;
    int base_i, last_i;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mode_of(input int p);
        if (p == 0) return 1;
        if (p == 2) return 2;
        return 0;
    endfunction

    function automatic bit in_win(input int c);
        return (c >= base_i) && (c <= base_i + last_i);
    endfunction

    function automatic int win_mask();
        int m = 0;
        for (int c = 0; c < NCH; c++) if (in_win(c)) m |= (1 << c);
        return m;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 0; m_gnd[c] = 0; m_sup[c] = 0; m_sig[c] = 0;
        end
        m_ph = 0; m_cnt = 0; m_mode = 1; m_ack = 0; m_stb = 0; m_idx = 0;
    endtask

    task automatic compare();
        int r;
        string lreq;
        r = int'(rd_ch);
        lreq = in_win(r) ? "R6" : "R3";
        chk("R5", "chan_mode", int'(chan_mode), m_mode);
        chk("R10", "phase", int'(phase), m_ph);
        chk("R2", "conv_ack", int'(conv_ack), m_ack);
        chk("R8", "calc_stb", int'(calc_stb), m_stb);
        if (m_stb != 0) chk("R8", "calc_idx", int'(calc_idx), m_idx);
        chk(lreq, "gnd_level", int'(gnd_level), m_gnd[r]);
        chk(lreq, "sup_level", int'(sup_level), m_sup[r]);
        chk(lreq, "sig_level", int'(sig_level), m_sig[r]);
    endtask

    // one clock: check outputs, drive next inputs, advance the reference
    task automatic step(input logic [NCH-1:0] dv, input int pat);
        int d[NCH];
        bit ev;
        @(negedge clk);
        compare();
        steps++;
        for (int c = 0; c < NCH; c++) begin
            if (pat == 0)      d[c] = 1023;
            else if (pat == 1) d[c] = int'($urandom_range(0, 1023));
            else               d[c] = c * 90 + m_cnt * 7 + 3;
            conv_data[c*DW +: DW] = DW'(d[c]);
        end
        conv_done = dv;
        rd_ch = 3'(steps % NCH);
        ev = dv[base_i] && (m_ack == 0);
        m_ack = ev ? win_mask() : 0;
        m_stb = 0;
        if (ev) begin
            if (m_cnt < 8) begin
                for (int c = 0; c < NCH; c++) if (in_win(c)) m_acc[c] += d[c];
                m_stb = 1;
                m_idx = m_cnt;
                if (m_cnt == 7) m_mode = mode_of((m_ph + 1) % 4);
            end else if (m_cnt == 8) begin
                for (int c = 0; c < NCH; c++) begin
                    if (m_ph == 0)      m_gnd[c] = m_acc[c];
                    else if (m_ph == 2) m_sup[c] = m_acc[c];
                    else                m_sig[c] = m_acc[c];
                end
            end else begin
                for (int c = 0; c < NCH; c++) m_acc[c] = 0;
                m_ph = (m_ph + 1) % 4;
            end
            m_cnt = (m_cnt + 1) % 10;
        end
    endtask

    task automatic run_cfg(input int b, input int l, input int pat,
                           input bit hold, input bit noise);
        logic [NCH-1:0] dv;
        base_i = b; last_i = l;
        cfg_base = 3'(b); cfg_last = 3'(l);
        conv_done = '0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1", "mode in reset", int'(chan_mode), 1);
        chk("R1", "phase in reset", int'(phase), 0);
        chk("R1", "ack in reset", int'(conv_ack), 0);
        chk("R1", "stb in reset", int'(calc_stb), 0);
        chk("R1", "gnd in reset", int'(gnd_level), 0);
        rst_n = 1'b1;
        dv = NCH'(win_mask());
        for (int ev = 0; ev < 80; ev++) begin
            if (noise && (ev % 5 == 0)) begin
                step(NCH'(1 << ((b + 1) % NCH)), pat); // R2: non-base done ignored
                step('0, pat);
            end
            step(dv, pat);
            if (hold) step(dv, pat);               // R2: done held into ack cycle
            step('0, pat);
            step('0, pat);
        end
        step('0, pat);
    endtask

    initial begin
        run_cfg(0, 7, 0, 0, 0);   // R9 full scale, full window
        run_cfg(0, 7, 1, 1, 1);   // R4 random data, hold and noise
        run_cfg(5, 2, 2, 0, 1);   // R3 top window
        run_cfg(6, 7, 1, 0, 0);   // R3 window clipped at last channel
        run_cfg(3, 0, 2, 1, 0);   // R3 single channel
        run_cfg(2, 3, 1, 0, 1);   // R6 R7 mid window
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule